// File: doc/BRIEF.md
# Event Latency Extreme Tracker

This block measures how much the timing of a periodic event varies. Logic outside the block runs a free counter and raises a one-cycle sample strobe at a fixed point after each event. On that strobe the block takes the counter value and updates its record of the smallest and largest values seen since reset. If the smallest and largest values stay equal over a long run, the event has no timing jitter. The distance between them is the jitter, measured in counter ticks.

The first strobe after reset loads the one value it carries into both records. Every later strobe compares the value against the records as an unsigned number. The result drives an 8-bit indicator port. The low nibble shows the bottom four bits of the minimum and the high nibble shows the bottom four bits of the maximum. The whole byte is complemented, so an indicator lights when its bit is 0. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `latency_monitor`

## Requirements
- R1: After reset is released and before any strobe, port_o reads 8'hFF (all indicators dark).
- R2: The first strobe after reset loads its count value into both the minimum and the maximum, with no comparison.
- R3: On a later strobe, the minimum takes the new value only when that value is strictly below the current minimum. An equal value leaves it unchanged.
- R4: On a later strobe, the maximum takes the new value only when that value is strictly above the current maximum. An equal value leaves it unchanged.
- R5: port_o equals the bitwise complement of {max[3:0], min[3:0]}: bits 3:0 carry the minimum and bits 7:4 carry the maximum.
- R6: port_o changes only at the clock edge where the strobe is high, so the result is visible one cycle after the strobe. Changes on count_i without a strobe have no effect.
- R7: Comparisons are unsigned over 8 bits, so 8'h87 counts as larger than 8'h4C and 8'hFF is the largest value.
- R8: Asserting rst_n clears the seeded state, so the first strobe after a reset in mid-run seeds both extremes again.
- R9: Asserting rst_n low drives port_o to 8'hFF at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sample_i | input | 1 | Strobe: capture count_i this cycle |
| count_i | input | 8 | Counter value at the fixed point after the event |
| port_o | output | 8 | Complemented packed min/max nibbles for active-low indicators |

## Verification
The bench builds the block with its default 8-bit value width and 4-bit nibble width. These widths make the ends of the unsigned range reachable: 0 and 8'hFF, and the 8'h7F/8'h80 boundary where a signed comparison would go wrong. Most of the stimulus values are above 15, so the checks also show that only the low nibble of each extreme reaches the port. Among the stimulus values are some equal to an existing extreme, so the bench can confirm that the strict comparison keeps the stored value.

// File: rtl/latmon_pkg.sv
package latmon_pkg;
  typedef enum logic {TRACK_MIN = 1'b0, TRACK_MAX = 1'b1} track_e;
endpackage

// File: rtl/latmon_rst_sync.sv
module latmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/latmon_extreme.sv
module latmon_extreme
  import latmon_pkg::*;
#(
  parameter int     DATA_W = 8,
  parameter track_e KIND   = TRACK_MIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              seed_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] nxt_o,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] ext_q;
  logic              better;

  generate
    if (KIND == TRACK_MAX) begin : g_max
      always_comb better = (val_i > ext_q);
    end else begin : g_min
      always_comb better = (val_i < ext_q);
    end
  endgenerate

  always_comb begin
    nxt_o = ext_q;
    if (en_i && (seed_i || better)) nxt_o = val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ext_q <= '0;
    else if (en_i) ext_q <= nxt_o;
  end

  assign q_o = ext_q;
endmodule

// File: rtl/latmon_pack.sv
module latmon_pack #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0]  min_i,
  input  logic [DATA_W-1:0]  max_i,
  output logic [2*NIB_W-1:0] leds_o
);
  always_comb leds_o = ~{max_i[NIB_W-1:0], min_i[NIB_W-1:0]};
endmodule

// File: rtl/latency_monitor.sv
module latency_monitor
  import latmon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_i,
  input  logic [DATA_W-1:0]   count_i,
  output logic [2*NIB_W-1:0]  port_o
);
  localparam int PORT_W = 2 * NIB_W;

  logic              rst_sync_n;
  logic              init_q, init_d;
  logic [DATA_W-1:0] min_q, min_nxt, max_q, max_nxt;
  logic [PORT_W-1:0] port_q, port_d;

  latmon_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  latmon_extreme #(.DATA_W(DATA_W), .KIND(TRACK_MIN)) u_min (
    .clk(clk), .rst_n(rst_sync_n), .en_i(sample_i), .seed_i(!init_q),
    .val_i(count_i), .nxt_o(min_nxt), .q_o(min_q)
  );

  latmon_extreme #(.DATA_W(DATA_W), .KIND(TRACK_MAX)) u_max (
    .clk(clk), .rst_n(rst_sync_n), .en_i(sample_i), .seed_i(!init_q),
    .val_i(count_i), .nxt_o(max_nxt), .q_o(max_q)
  );

  latmon_pack #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_pack (
    .min_i(min_nxt), .max_i(max_nxt), .leds_o(port_d)
  );

  always_comb init_d = init_q | sample_i;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      init_q <= 1'b0;
      port_q <= '1;
    end else begin
      init_q <= init_d;
      if (sample_i) port_q <= port_d;
    end
  end

  assign port_o = port_q;
endmodule

// File: rtl/latmon_chk.sv
module latmon_chk #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                sample_i,
  input logic [DATA_W-1:0]   count_i,
  input logic [2*NIB_W-1:0]  port_o,
  input logic                init_q,
  input logic [DATA_W-1:0]   min_q,
  input logic [DATA_W-1:0]   max_q
);
  a_r2_first_seed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!init_q && sample_i) |=> (min_q == $past(count_i) && max_q == $past(count_i)));

  a_r3_min_never_rises: assert property (@(posedge clk) disable iff (!rst_sync_n)
    init_q |=> (min_q <= $past(min_q)));

  a_r4_max_never_falls: assert property (@(posedge clk) disable iff (!rst_sync_n)
    init_q |=> (max_q >= $past(max_q)));

  a_r3_min_takes_lower: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (init_q && sample_i && count_i < min_q) |=> (min_q == $past(count_i)));

  a_r4_max_takes_higher: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (init_q && sample_i && count_i > max_q) |=> (max_q == $past(count_i)));

  a_r5_port_matches: assert property (@(posedge clk) disable iff (!rst_sync_n)
    init_q |-> (port_o == ~{max_q[NIB_W-1:0], min_q[NIB_W-1:0]}));

  a_r6_port_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sample_i |=> $stable(port_o));

  a_r8_flag_sticks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    init_q |=> init_q);
endmodule

bind latency_monitor latmon_chk #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .sample_i(sample_i), .count_i(count_i),
  .port_o(port_o), .init_q(init_q), .min_q(min_q), .max_q(max_q)
);

// File: tb/latency_monitor_bench.sv
module latency_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_i = 1'b0;
  logic [7:0] count_i = 8'h00;
  logic [7:0] port_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  latency_monitor u_latency_monitor (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .count_i(count_i), .port_o(port_o)
  );

  // {count value, expected port after strobe}
  localparam logic [15:0] VEC [10] = '{
    {8'h35, 8'hAA}, {8'h4C, 8'h3A}, {8'h21, 8'h3E}, {8'h30, 8'h3E}, {8'h21, 8'h3E},
    {8'h4C, 8'h3E}, {8'h87, 8'h8E}, {8'h00, 8'h8F}, {8'hFF, 8'h0F}, {8'h7E, 8'h0F}
  };

  task automatic check(input logic [7:0] exp, input string req);
    n_chk++;
    if (port_o !== exp) begin
      n_fail++;
      $display("FAIL %s: port_o=%h expected %h", req, port_o, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] v);
    @(negedge clk);
    sample_i = 1'b1;
    count_i  = v;
    @(negedge clk);
    sample_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(8'hFF, "R1 reset state");

    for (int i = 0; i < 10; i++) begin
      strobe(VEC[i][15:8]);
      check(VEC[i][7:0], $sformatf("R2/R3/R4/R5/R7 vector %0d", i));
    end

    // R6: count changes without strobe are ignored
    count_i = 8'h00;
    @(negedge clk);
    check(8'h0F, "R6 hold low count");
    count_i = 8'hF3;
    @(negedge clk);
    check(8'h0F, "R6 hold high count");

    // R9: asynchronous assertion clears the port before any edge
    #2 rst_n = 1'b0;
    #1 check(8'hFF, "R9 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(8'hFF, "R1 after mid-run reset");

    // R8: reseed after reset
    strobe(8'h96);
    check(8'h99, "R8 reseed after reset");
    strobe(8'h96);
    check(8'h99, "R3 R4 equal value keeps both");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule